// File: doc/BRIEF.md
# UART Receiver With Break Detection

This block turns an asynchronous serial line into a stream of characters. The line must already be synchronous to the block clock. The receiver takes one sample of the line per bit period, at the middle of each bit. A programmable divisor gives the number of clock cycles in one bit period. A start bit counts only if the line is still low half a bit period after the falling edge. After that the receiver reads 5 to 8 data bits (or 9 in nine-bit mode), least significant bit first, then an optional parity bit, then one stop bit.

For each character the block writes one word into a receive FIFO through a registered write port. The word holds the data byte and three flags. The first flag is a parity mismatch, or the ninth data bit in nine-bit mode. The second flag marks a low stop bit. The third flag marks a break. A frame that is low from the start bit through the stop bit is a break. It yields exactly one all-zero character flagged as a break. The receiver then waits for the line to go high again. When a stop bit is low but the frame is not a break, the receiver treats that low sample as the start bit of the next character and carries on from there. When the FIFO reports full at the moment of a push, the character is dropped and a one-cycle overrun pulse is raised instead.

Top module: `uart_rx_brk`

## Requirements
- R1: While and after a synchronous active-high reset, `wr_en` and `overrun` are low until a character completes.
- R2: A low level on `rxd` seen in idle at clock edge t0 is checked at edge t0 + floor(D/2), where D = `bit_period` (D >= 4). If `rxd` is high there, the receiver returns to idle and pushes nothing. Otherwise each later bit is sampled exactly D cycles after the previous sample.
- R3: `data_len` sets the character length: 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Bits are received least significant first, and `wr_data` bits above the length are 0.
- R4: When `par_en`=1 outside nine-bit mode, a parity bit follows the data and is checked according to `par_sel`: 0 odd, 1 even, 2 always 1, 3 always 0. A mismatch sets `wr_flag9`.
- R5: When `par_en`=0, no parity bit is expected and `wr_flag9` is 0 for ordinary characters.
- R6: When `nine_bit`=1, nine data bits are received and no parity bit is expected, whatever `par_en` holds. Bits 0 to 7 go to `wr_data` and bit 8 goes to `wr_flag9`.
- R7: A character whose stop sample is 0, and which is not a break, is pushed with `wr_ferr`=1.
- R8: After such a framing error, the low stop sample serves as the next start bit. The first data bit of the next character is sampled D cycles later, with the same configuration.
- R9: If the start, data, parity and stop samples are all 0, one character is pushed with `wr_data`=0, `wr_brk`=1, `wr_flag9`=0 and `wr_ferr`=0. No further character is started until `rxd` has been seen high.
- R10: If `fifo_full` is high at the stop-sample edge, `wr_en` stays low and `overrun` pulses for one cycle in the cycle where the write would have appeared. Otherwise `overrun` stays low.
- R11: A completed character appears as a one-cycle `wr_en` pulse in the cycle after its stop-sample edge. The data and all flags are valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial line, idle high, synchronous to clk |
| bit_period | input | DIV_W | Clock cycles per bit, at least 4 |
| data_len | input | 2 | Data bits minus five (ignored in nine-bit mode) |
| nine_bit | input | 1 | Nine-bit character mode |
| par_en | input | 1 | Parity bit present and checked |
| par_sel | input | 2 | Parity kind: odd, even, always 1, always 0 |
| fifo_full | input | 1 | Receive FIFO has no room |
| wr_en | output | 1 | FIFO write strobe |
| wr_data | output | 8 | Received data bits 0 to 7 |
| wr_flag9 | output | 1 | Parity mismatch, or data bit 8 in nine-bit mode |
| wr_ferr | output | 1 | Stop bit sampled low |
| wr_brk | output | 1 | Break character |
| overrun | output | 1 | Character dropped because the FIFO was full |

## Verification
At a framing error, a single clock edge both pushes the flagged character and starts the next reception, because the low stop sample becomes the next start bit. The bench provokes this by sending a character whose stop bit is low and following it directly with the data bits of a second character, with no start bit of its own. The reference model predicts both push cycles: the second one falls exactly (data bits + parity + 1) bit periods after the first. The model is compared with the outputs on every clock, so a lost resynchronization or an off-by-one-bit sample shows up as a wrong cycle or a wrong byte.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int CHAR_W = 8;
  localparam int MAX_BITS = 9;
  localparam int IDX_W = $clog2(MAX_BITS + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_BRKWAIT
  } rx_state_t;

  typedef enum logic [1:0] {
    PK_ODD   = 2'd0,
    PK_EVEN  = 2'd1,
    PK_MARK  = 2'd2,
    PK_SPACE = 2'd3
  } par_kind_t;

  typedef struct packed {
    logic [CHAR_W-1:0] data;
    logic              flag9;
    logic              ferr;
    logic              brk;
  } rx_word_t;

  function automatic logic [IDX_W-1:0] char_bits(input logic [1:0] len, input logic nine);
    if (nine) return IDX_W'(MAX_BITS);
    return IDX_W'(5) + IDX_W'(len);
  endfunction

endpackage

// File: rtl/uart_rx_bit_timer.sv
module uart_rx_bit_timer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_half,
  input  logic             run,
  input  logic [DIV_W-1:0] period,
  output logic             tick
);

  logic [DIV_W-1:0] per_q;
  logic [DIV_W-1:0] cnt_q;

  // The period is captured when a reception begins and kept until it ends.
  always_ff @(posedge clk) begin
    if (rst) begin
      per_q <= '0;
      cnt_q <= '0;
    end else if (load_half) begin
      per_q <= period;
      cnt_q <= (period >> 1) - DIV_W'(1);
    end else if (run) begin
      if (cnt_q == '0) cnt_q <= per_q - DIV_W'(1);
      else             cnt_q <= cnt_q - DIV_W'(1);
    end
  end

  assign tick = run && (cnt_q == '0);

endmodule

// File: rtl/uart_rx_parity_chk.sv
module uart_rx_parity_chk
  import uart_rx_pkg::*;
(
  input  logic [CHAR_W-1:0] data,
  input  logic              par_bit,
  input  logic [1:0]        kind,
  output logic              mismatch
);

  logic ones_odd;
  assign ones_odd = ^{data, par_bit};

  always_comb begin
    unique case (par_kind_t'(kind))
      PK_ODD:   mismatch = !ones_odd;
      PK_EVEN:  mismatch = ones_odd;
      PK_MARK:  mismatch = !par_bit;
      PK_SPACE: mismatch = par_bit;
      default:  mismatch = 1'b0;
    endcase
  end

endmodule

// File: rtl/uart_rx_frame_ctl.sv
module uart_rx_frame_ctl
  import uart_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     rxd,
  input  logic     tick,
  input  logic [1:0] data_len,
  input  logic     nine_bit,
  input  logic     par_en,
  input  logic [1:0] par_sel,
  output logic     load_half,
  output logic     run,
  output logic     push,
  output rx_word_t push_word
);

  rx_state_t        state_q;
  logic [IDX_W-1:0] idx_q;
  logic [MAX_BITS-1:0] shreg_q;
  logic             par_q;
  logic             seen_one_q;
  logic [1:0]       len_q;
  logic             nine_q;
  logic             pen_q;
  logic [1:0]       psel_q;

  logic [IDX_W-1:0] last_idx;
  logic             use_par;
  logic             par_bad;
  logic             stop_tick;
  logic             is_break;

  assign last_idx  = char_bits(len_q, nine_q) - IDX_W'(1);
  assign use_par   = pen_q && !nine_q;
  assign load_half = (state_q == ST_IDLE) && !rxd;
  assign run       = (state_q != ST_IDLE) && (state_q != ST_BRKWAIT);
  assign stop_tick = (state_q == ST_STOP) && tick;
  assign is_break  = !rxd && !seen_one_q;

  uart_rx_parity_chk u_par (
    .data     (shreg_q[CHAR_W-1:0]),
    .par_bit  (par_q),
    .kind     (psel_q),
    .mismatch (par_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      shreg_q    <= '0;
      par_q      <= 1'b0;
      seen_one_q <= 1'b0;
      len_q      <= '0;
      nine_q     <= 1'b0;
      pen_q      <= 1'b0;
      psel_q     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (!rxd) begin
            state_q    <= ST_START;
            len_q      <= data_len;
            nine_q     <= nine_bit;
            pen_q      <= par_en;
            psel_q     <= par_sel;
            shreg_q    <= '0;
            par_q      <= 1'b0;
            seen_one_q <= 1'b0;
          end
        end
        ST_START: begin
          if (tick) begin
            idx_q   <= '0;
            state_q <= rxd ? ST_IDLE : ST_DATA;
          end
        end
        ST_DATA: begin
          if (tick) begin
            shreg_q    <= shreg_q | (MAX_BITS'(rxd) << idx_q);
            seen_one_q <= seen_one_q | rxd;
            if (idx_q == last_idx) state_q <= use_par ? ST_PAR : ST_STOP;
            else                   idx_q   <= idx_q + IDX_W'(1);
          end
        end
        ST_PAR: begin
          if (tick) begin
            par_q      <= rxd;
            seen_one_q <= seen_one_q | rxd;
            state_q    <= ST_STOP;
          end
        end
        ST_STOP: begin
          if (tick) begin
            if (is_break) begin
              state_q <= ST_BRKWAIT;
            end else if (!rxd) begin
              // The low stop sample becomes the start bit of the next character.
              state_q    <= ST_DATA;
              idx_q      <= '0;
              shreg_q    <= '0;
              par_q      <= 1'b0;
              seen_one_q <= 1'b0;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_BRKWAIT: begin
          if (rxd) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    push = stop_tick;
    if (is_break) begin
      push_word = '{data: '0, flag9: 1'b0, ferr: 1'b0, brk: 1'b1};
    end else begin
      push_word.data  = shreg_q[CHAR_W-1:0];
      push_word.flag9 = nine_q ? shreg_q[MAX_BITS-1] : (use_par && par_bad);
      push_word.ferr  = !rxd;
      push_word.brk   = 1'b0;
    end
  end

endmodule

// File: rtl/uart_rx_push_reg.sv
module uart_rx_push_reg
  import uart_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     push,
  input  rx_word_t word,
  input  logic     fifo_full,
  output logic     wr_en,
  output rx_word_t wr_word,
  output logic     overrun
);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      overrun <= 1'b0;
      wr_word <= '0;
    end else begin
      wr_en   <= push && !fifo_full;
      overrun <= push && fifo_full;
      if (push && !fifo_full) wr_word <= word;
    end
  end

endmodule

// File: rtl/uart_rx_brk.sv
module uart_rx_brk
  import uart_rx_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rxd,
  input  logic [DIV_W-1:0] bit_period,
  input  logic [1:0]       data_len,
  input  logic             nine_bit,
  input  logic             par_en,
  input  logic [1:0]       par_sel,
  input  logic             fifo_full,
  output logic             wr_en,
  output logic [7:0]       wr_data,
  output logic             wr_flag9,
  output logic             wr_ferr,
  output logic             wr_brk,
  output logic             overrun
);

  logic     load_half;
  logic     run;
  logic     tick;
  logic     push;
  rx_word_t push_word;
  rx_word_t out_word;

  uart_rx_bit_timer #(.DIV_W(DIV_W)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .load_half (load_half),
    .run       (run),
    .period    (bit_period),
    .tick      (tick)
  );

  uart_rx_frame_ctl u_ctl (
    .clk       (clk),
    .rst       (rst),
    .rxd       (rxd),
    .tick      (tick),
    .data_len  (data_len),
    .nine_bit  (nine_bit),
    .par_en    (par_en),
    .par_sel   (par_sel),
    .load_half (load_half),
    .run       (run),
    .push      (push),
    .push_word (push_word)
  );

  uart_rx_push_reg u_push (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .word      (push_word),
    .fifo_full (fifo_full),
    .wr_en     (wr_en),
    .wr_word   (out_word),
    .overrun   (overrun)
  );

  assign wr_data  = out_word.data;
  assign wr_flag9 = out_word.flag9;
  assign wr_ferr  = out_word.ferr;
  assign wr_brk   = out_word.brk;

endmodule

// File: rtl/uart_rx_brk_chk.sv
module uart_rx_brk_chk (
  input logic       clk,
  input logic       rst,
  input logic       rxd,
  input logic       fifo_full,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       wr_flag9,
  input logic       wr_ferr,
  input logic       wr_brk,
  input logic       overrun
);

  AST_WRITE_OR_DROP: assert property (@(posedge clk) disable iff (rst) !(wr_en && overrun)); // R10
  AST_DROP_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst) overrun |-> $past(fifo_full)); // R10
  AST_WRITE_NEEDS_ROOM: assert property (@(posedge clk) disable iff (rst) wr_en |-> !$past(fifo_full)); // R10
  AST_BREAK_IS_ZERO: assert property (@(posedge clk) disable iff (rst) (wr_en && wr_brk) |-> (wr_data == 8'h00 && !wr_flag9 && !wr_ferr)); // R9
  AST_BREAK_STOP_LOW: assert property (@(posedge clk) disable iff (rst) (wr_en && wr_brk) |-> !$past(rxd)); // R9
  AST_FERR_STOP_LOW: assert property (@(posedge clk) disable iff (rst) (wr_en && wr_ferr) |-> !$past(rxd)); // R7
  AST_WRITE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) wr_en |=> !wr_en); // R11

endmodule

bind uart_rx_brk uart_rx_brk_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .rxd       (rxd),
  .fifo_full (fifo_full),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .wr_flag9  (wr_flag9),
  .wr_ferr   (wr_ferr),
  .wr_brk    (wr_brk),
  .overrun   (overrun)
);

// File: tb/tb_uart_rx_brk.sv
`timescale 1ns/1ps
module tb_uart_rx_brk;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rxd = 1'b1;
  logic [15:0] bit_period = 16'd8;
  logic [1:0]  data_len = 2'd3;
  logic        nine_bit = 1'b0;
  logic        par_en = 1'b0;
  logic [1:0]  par_sel = 2'd0;
  logic        fifo_full = 1'b0;
  logic        wr_en;
  logic [7:0]  wr_data;
  logic        wr_flag9;
  logic        wr_ferr;
  logic        wr_brk;
  logic        overrun;

  always #2.5 clk = ~clk;

  uart_rx_brk #(.DIV_W(16)) dut (
    .clk(clk), .rst(rst), .rxd(rxd), .bit_period(bit_period),
    .data_len(data_len), .nine_bit(nine_bit), .par_en(par_en), .par_sel(par_sel),
    .fifo_full(fifo_full), .wr_en(wr_en), .wr_data(wr_data), .wr_flag9(wr_flag9),
    .wr_ferr(wr_ferr), .wr_brk(wr_brk), .overrun(overrun)
  );

  typedef struct {
    int         cyc;
    logic [7:0] d;
    logic       f9;
    logic       fe;
    logic       br;
    logic       ov;
    string      tag;
  } exp_t;

  exp_t  q[$];
  int    cyc = 0;
  int    n_vec = 0;
  int    n_bad = 0;
  int    last_p = 0;
  bit    done = 1'b0;
  string idle_tag = "R1";

  always @(posedge clk) cyc <= cyc + 1;

  // Reference comparison, one vector per clock, away from the active edge.
  always @(negedge clk) begin
    if (!rst && !done) begin
      n_vec++;
      if (q.size() > 0 && q[0].cyc < cyc) begin
        n_bad++;
        $display("FAIL %s: expected push at cycle %0d never seen (now %0d)", q[0].tag, q[0].cyc, cyc);
        void'(q.pop_front());
      end
      if (q.size() > 0 && q[0].cyc == cyc) begin
        exp_t e;
        e = q.pop_front();
        if (e.ov) begin
          if (wr_en !== 1'b0 || overrun !== 1'b1) begin
            n_bad++;
            $display("FAIL %s: wr_en=%0b overrun=%0b, expected wr_en=0 overrun=1", e.tag, wr_en, overrun);
          end
        end else if (wr_en !== 1'b1 || overrun !== 1'b0 || wr_data !== e.d ||
                     wr_flag9 !== e.f9 || wr_ferr !== e.fe || wr_brk !== e.br) begin
          n_bad++;
          $display("FAIL %s: got en=%0b ov=%0b d=%h f9=%0b fe=%0b br=%0b, expected en=1 ov=0 d=%h f9=%0b fe=%0b br=%0b",
                   e.tag, wr_en, overrun, wr_data, wr_flag9, wr_ferr, wr_brk, e.d, e.f9, e.fe, e.br);
        end
      end else if (wr_en !== 1'b0 || overrun !== 1'b0) begin
        n_bad++;
        $display("FAIL %s: got wr_en=%0b overrun=%0b, expected both 0", idle_tag, wr_en, overrun);
      end
    end
  end

  task automatic hold_bit(input logic v);
    rxd = v;
    repeat (int'(bit_period)) @(negedge clk);
  endtask

  // Sends one character; with cont set the start bit is omitted and timing
  // continues from the previous low stop sample.
  task automatic frame(input logic [8:0] d, input bit bad_par, input bit stop_bad,
                       input bit cont, input string tag);
    int nb, k, dd, p;
    bit has_par;
    logic [8:0] dm;
    logic pbit;
    exp_t e;
    dd = int'(bit_period);
    nb = nine_bit ? 9 : 5 + int'(data_len);
    has_par = par_en && !nine_bit;
    dm = d & 9'((1 << nb) - 1);
    case (par_sel)
      2'd0: pbit = ~^dm[7:0];
      2'd1: pbit = ^dm[7:0];
      2'd2: pbit = 1'b1;
      default: pbit = 1'b0;
    endcase
    if (bad_par) pbit = ~pbit;
    k = nb + (has_par ? 1 : 0) + 1;
    p = cont ? last_p + k * dd : cyc + 1 + dd / 2 + k * dd;
    last_p = p;
    e.cyc = p;
    e.d   = dm[7:0];
    e.f9  = nine_bit ? dm[8] : (has_par ? bad_par : 1'b0);
    e.fe  = stop_bad;
    e.br  = 1'b0;
    e.ov  = fifo_full;
    e.tag = tag;
    q.push_back(e);
    idle_tag = tag;
    if (!cont) hold_bit(1'b0);
    for (int i = 0; i < nb; i++) hold_bit(dm[i]);
    if (has_par) hold_bit(pbit);
    hold_bit(!stop_bad);
  endtask

  task automatic send_break(input string tag);
    int nb, k, dd;
    exp_t e;
    dd = int'(bit_period);
    nb = nine_bit ? 9 : 5 + int'(data_len);
    k = nb + ((par_en && !nine_bit) ? 1 : 0) + 1;
    e.cyc = cyc + 1 + dd / 2 + k * dd;
    e.d = 8'h00; e.f9 = 1'b0; e.fe = 1'b0; e.br = 1'b1; e.ov = fifo_full; e.tag = tag;
    q.push_back(e);
    idle_tag = tag;
    rxd = 1'b0;
    repeat ((k + 4) * dd) @(negedge clk);   // stays low well past the push: no new start
    rxd = 1'b1;
    repeat (2 * dd) @(negedge clk);
  endtask

  task automatic gap(input int n);
    rxd = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: outputs quiet during reset
    n_vec++;
    if (wr_en !== 1'b0 || overrun !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: wr_en=%0b overrun=%0b during reset, expected 0 0", wr_en, overrun);
    end
    rst = 1'b0;
    gap(20);

    // R3 R5: eight data bits, no parity
    data_len = 2'd3; par_en = 1'b0;
    frame(9'h0A5, 0, 0, 0, "R5");
    frame(9'h03C, 0, 0, 0, "R3");
    gap(5);
    // R3: shorter characters, upper bits must read 0
    data_len = 2'd0; frame(9'h0F5, 0, 0, 0, "R3");
    data_len = 2'd2; frame(9'h0DA, 0, 0, 0, "R3");
    data_len = 2'd1; frame(9'h02B, 0, 0, 0, "R3");
    gap(5);

    // R4: every parity kind, correct and wrong
    data_len = 2'd3; par_en = 1'b1;
    for (int s = 0; s < 4; s++) begin
      par_sel = 2'(s);
      frame(9'h06B, 0, 0, 0, "R4");
      frame(9'h06B, 1, 0, 0, "R4");
      frame(9'h000, 1, 0, 0, "R4");
    end
    gap(5);

    // R6: nine-bit mode with par_en set but ignored
    nine_bit = 1'b1; par_sel = 2'd1;
    frame(9'h1A5, 0, 0, 0, "R6");
    frame(9'h05A, 0, 0, 0, "R6");
    nine_bit = 1'b0; par_en = 1'b0;
    gap(5);

    // R7 R8: low stop bit then a character that uses it as its start
    frame(9'h081, 0, 1, 0, "R7");
    frame(9'h042, 0, 0, 1, "R8");
    gap(5);
    par_en = 1'b1; par_sel = 2'd0; data_len = 2'd2;
    frame(9'h011, 0, 1, 0, "R7");
    frame(9'h07E, 1, 1, 1, "R8");
    frame(9'h033, 0, 0, 1, "R8");
    gap(5);

    // R9: break with parity on, then a normal character
    data_len = 2'd3; par_sel = 2'd1;
    send_break("R9");
    frame(9'h0C3, 0, 0, 0, "R9");
    par_en = 1'b0;
    send_break("R9");
    gap(5);

    // R10: FIFO full drops the character
    fifo_full = 1'b1;
    frame(9'h077, 0, 0, 0, "R10");
    fifo_full = 1'b0;
    frame(9'h088, 0, 0, 0, "R10");
    gap(5);

    // R2: short low glitch is not a start bit
    idle_tag = "R2";
    rxd = 1'b0; @(negedge clk);
    gap(3 * int'(bit_period));
    // R2 R11: another divisor
    bit_period = 16'd5; data_len = 2'd1;
    frame(9'h02D, 0, 0, 0, "R2");
    frame(9'h012, 0, 0, 0, "R11");
    idle_tag = "R2";
    rxd = 1'b0; @(negedge clk);
    gap(3 * int'(bit_period));
    bit_period = 16'd7; data_len = 2'd3;
    frame(9'h0E1, 0, 0, 0, "R11");
    gap(20);

    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL R11: %0d expected writes never appeared", q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion before cycle 150000");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule